// File: doc/BRIEF.md
# Label-Filtered Receive Word Queue

This block sits behind a 32-bit serial word receiver. Each time the receiver completes a word it raises a one-cycle end-of-word strobe with the word alongside. The block then decides whether the word is kept. Two checks are available, and each has its own enable. The first compares the word's 8-bit label with a 16-entry table that the host loads. The second requires word bits 10 and 9 to equal two host-programmed values. A word that passes every enabled check is appended to a 4-deep, 32-bit queue. A word that fails is dropped, and no flag or stored entry changes.

The host drains the queue through a pop strobe. The popped word appears on a registered read output. Three flags report the queue state: empty, full and data-ready. When the queue is full, a newly accepted word is not discarded. It takes the place of the most recently stored word, so the oldest words survive until the host reads them.

Top module: `arw_label_filter`

## Requirements
- R1: The label is word bits [7:0]. With `lbl_chk_en`=1, a word passes the label check only if its label equals one of the 16 table entries.
- R2: With `lbl_chk_en`=0, every word passes the label check.
- R3: With `pair_chk_en`=1, a word passes the bit check only if word[9] (bit 10) equals `want_b10` and word[8] (bit 9) equals `want_b9`. With `pair_chk_en`=0, the bit check always passes.
- R4: A word is stored only when `word_stb`=1 and every enabled check passes. A rejected word changes no flag and no queue content.
- R5: Label value 8'h00 is matched like any other value. Every table entry resets to 8'h00.
- R6: The queue holds up to 4 words of 32 bits in arrival order. A pop with the queue non-empty places the oldest word on `rd_word` after the clock edge and removes it from the queue.
- R7: `full`=1 exactly when 4 words are held. An accepted word arriving while the queue is full, with no pop in that cycle, replaces the most recently stored word.
- R8: Storing a word clears `empty` and sets `data_ready` after the edge. Both flags stay in that state until the queue is drained.
- R9: A pop while the queue is empty leaves `rd_word`, the flags and the queue contents unchanged.
- R10: `tbl_we` writes `tbl_wdata` into entry `tbl_addr` (4 bits). The new value is used from the next cycle on, so a word arriving in the same cycle as the write is compared against the old value.
- R11: If the queue is full and a pop and an accepted word occur in the same cycle, the pop is applied first and the word is then appended. The queue stays full.
- R12: Synchronous active-high `rst` sets `empty`=1, `full`=0, `data_ready`=0 and `rd_word`=0, and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 32 | Completed received word |
| word_stb | input | 1 | One-cycle end-of-word strobe |
| lbl_chk_en | input | 1 | Enable for the label-table check |
| pair_chk_en | input | 1 | Enable for the bit 10/9 check |
| want_b10 | input | 1 | Required value of word bit 10 |
| want_b9 | input | 1 | Required value of word bit 9 |
| tbl_we | input | 1 | Label table write strobe |
| tbl_addr | input | 4 | Label table entry index |
| tbl_wdata | input | 8 | Label value to write |
| pop | input | 1 | Host pop request |
| rd_word | output | 32 | Last popped word |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds 4 words |
| data_ready | output | 1 | At least one word is waiting |

## Verification
The bench stresses the following corner cases:

- **Overwrite on full.** It overfills the queue and then drains it. A design that dropped the new word, or overwrote the oldest entry, would return the wrong fourth word.
- **Pop and load together while full.** A design that handled the load before the pop would lose a word or leave a stale entry behind.
- **Table write in the same cycle as a word.** This checks that the write becomes visible one cycle later. A design that bypassed the write would accept the word early.
- **Label 00 and the bit-pair check.** These show whether zero was treated as "no label" and whether bits 9 and 10 were swapped.
- **Pop on an empty queue.** A design that moved its pointers here would corrupt the queue order from then on.

// File: rtl/arw_pkg.sv
package arw_pkg;
    localparam int WORD_W   = 32;
    localparam int LBL_W    = 8;
    localparam int LBL_N    = 16;
    localparam int LBL_AW   = $clog2(LBL_N);
    localparam int Q_DEPTH  = 4;
    localparam int B9_POS   = 8;
    localparam int B10_POS  = 9;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LBL_W-1:0]  label_t;

    typedef struct packed {
        logic lbl_en;
        logic pair_en;
        logic b10;
        logic b9;
    } filt_ctl_t;

    typedef struct packed {
        logic   we;
        logic [LBL_AW-1:0] addr;
        label_t data;
    } tbl_wr_t;

    function automatic label_t label_of(input word_t w);
        return w[LBL_W-1:0];
    endfunction

    function automatic logic pair_ok(input word_t w, input filt_ctl_t c);
        return (!c.pair_en) || ((w[B10_POS] == c.b10) && (w[B9_POS] == c.b9));
    endfunction
endpackage

// File: rtl/arw_label_table.sv
module arw_label_table
    import arw_pkg::*;
#(
    parameter int N = LBL_N
) (
    input  logic    clk,
    input  logic    rst,
    input  tbl_wr_t wr,
    input  label_t  probe,
    output logic    hit
);
    label_t entry [N];
    logic [N-1:0] hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) entry[i] <= '0;
        end else if (wr.we) begin
            entry[wr.addr] <= wr.data;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = (entry[g] == probe);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/arw_accept.sv
module arw_accept
    import arw_pkg::*;
(
    input  word_t     word,
    input  logic      stb,
    input  filt_ctl_t ctl,
    input  logic      lbl_hit,
    output logic      keep
);
    logic lbl_pass;
    logic bit_pass;

    always_comb begin
        lbl_pass = (!ctl.lbl_en) || lbl_hit;
        bit_pass = pair_ok(word, ctl);
        keep     = stb && lbl_pass && bit_pass;
    end
endmodule

// File: rtl/arw_word_fifo.sv
module arw_word_fifo
    import arw_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t din,
    input  logic  pop,
    output word_t dout,
    output logic  is_empty,
    output logic  is_full,
    output logic  ready
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, cnt_nxt;
    word_t            dout_q;
    logic             ready_q;
    logic             do_pop, do_append, do_replace;

    assign is_empty = (count == '0);
    assign is_full  = (count == FULL_CNT);

    always_comb begin
        do_pop     = pop && !is_empty;
        do_append  = push && (!is_full || do_pop);
        do_replace = push && is_full && !do_pop;
        cnt_nxt    = count;
        if (do_append && !do_pop)      cnt_nxt = count + CNT_ONE;
        else if (do_pop && !do_append) cnt_nxt = count - CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            dout_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            if (do_pop) begin
                dout_q <= mem[rd_ptr];
                rd_ptr <= rd_ptr + PTR_ONE;
            end
            if (do_append) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= wr_ptr + PTR_ONE;
            end else if (do_replace) begin
                mem[wr_ptr - PTR_ONE] <= din;
            end
            count   <= cnt_nxt;
            ready_q <= (cnt_nxt != '0);
        end
    end

    assign dout  = dout_q;
    assign ready = ready_q;

    // R8
    push_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> !is_empty && ready);
    // R9
    idle_pop_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && is_empty && !push) |=> $stable(dout) && is_empty);
    // R6
    last_pop_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == CNT_ONE) |=> is_empty && !ready);
    // R11
    full_swap_stays_full_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && push && pop) |=> is_full);
    // R7
    full_replace_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && push && !pop) |=> is_full && $stable(rd_ptr));
endmodule

// File: rtl/arw_label_filter.sv
module arw_label_filter
    import arw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] word_in,
    input  logic        word_stb,
    input  logic        lbl_chk_en,
    input  logic        pair_chk_en,
    input  logic        want_b10,
    input  logic        want_b9,
    input  logic        tbl_we,
    input  logic [3:0]  tbl_addr,
    input  logic [7:0]  tbl_wdata,
    input  logic        pop,
    output logic [31:0] rd_word,
    output logic        empty,
    output logic        full,
    output logic        data_ready
);
    filt_ctl_t ctl;
    tbl_wr_t   twr;
    logic      lbl_hit;
    logic      keep;

    assign ctl = '{lbl_en: lbl_chk_en, pair_en: pair_chk_en,
                   b10: want_b10, b9: want_b9};
    assign twr = '{we: tbl_we, addr: tbl_addr, data: tbl_wdata};

    arw_label_table #(.N(LBL_N)) u_table (
        .clk   (clk),
        .rst   (rst),
        .wr    (twr),
        .probe (label_of(word_in)),
        .hit   (lbl_hit)
    );

    arw_accept u_accept (
        .word    (word_in),
        .stb     (word_stb),
        .ctl     (ctl),
        .lbl_hit (lbl_hit),
        .keep    (keep)
    );

    arw_word_fifo #(.DEPTH(Q_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (keep),
        .din      (word_in),
        .pop      (pop),
        .dout     (rd_word),
        .is_empty (empty),
        .is_full  (full),
        .ready    (data_ready)
    );

    // R4
    reject_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb && !keep && !pop) |=> $stable(empty) && $stable(full)
                                        && $stable(rd_word) && $stable(data_ready));
    // R3
    pair_mismatch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb && pair_chk_en && (word_in[9] != want_b10) && empty && !pop)
            |=> empty);
endmodule

// File: tb/arw_label_filter_bench.sv
module arw_label_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] word_in;
    logic        word_stb, lbl_chk_en, pair_chk_en, want_b10, want_b9;
    logic        tbl_we, pop;
    logic [3:0]  tbl_addr;
    logic [7:0]  tbl_wdata;
    logic [31:0] rd_word;
    logic        empty, full, data_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0]  m_tbl [16];
    logic [31:0] m_q [4];
    int          m_cnt;
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    arw_label_filter u_arw_label_filter (
        .clk(clk), .rst(rst), .word_in(word_in), .word_stb(word_stb),
        .lbl_chk_en(lbl_chk_en), .pair_chk_en(pair_chk_en),
        .want_b10(want_b10), .want_b9(want_b9), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .pop(pop),
        .rd_word(rd_word), .empty(empty), .full(full), .data_ready(data_ready)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_accept(input logic [31:0] w);
        bit l = !lbl_chk_en;
        bit b;
        for (int i = 0; i < 16; i++) if (m_tbl[i] == w[7:0]) l = 1;
        b = !pair_chk_en || ((w[9] == want_b10) && (w[8] == want_b9));
        return word_stb && l && b;
    endfunction

    task automatic m_apply();
        bit acc = m_accept(word_in);
        if (pop && m_cnt > 0) begin
            m_rd = m_q[0];
            for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
            m_cnt--;
        end
        if (acc) begin
            if (m_cnt < 4) begin m_q[m_cnt] = word_in; m_cnt++; end
            else m_q[3] = word_in;
        end
        if (tbl_we) m_tbl[tbl_addr] = tbl_wdata;
    endtask

    task automatic compare(input string tag);
        chk(tag, "empty", 32'(empty), 32'(m_cnt == 0));
        chk(tag, "full", 32'(full), 32'(m_cnt == 4));
        chk(tag, "data_ready", 32'(data_ready), 32'(m_cnt != 0));
        chk(tag, "rd_word", rd_word, m_rd);
    endtask

    task automatic tick(input string tag);
        m_apply();
        @(posedge clk);
        #1;
        compare(tag);
        word_stb = 0; tbl_we = 0; pop = 0;
    endtask

    task automatic send(input logic [31:0] w, input string tag);
        word_in = w; word_stb = 1; tick(tag);
    endtask

    task automatic do_pop(input string tag);
        pop = 1; tick(tag);
    endtask

    task automatic twrite(input int a, input logic [7:0] d, input string tag);
        tbl_addr = 4'(a); tbl_wdata = d; tbl_we = 1; tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1; word_in = 0; word_stb = 0; lbl_chk_en = 0; pair_chk_en = 0;
        want_b10 = 0; want_b9 = 0; tbl_we = 0; tbl_addr = 0; tbl_wdata = 0; pop = 0;
        for (int i = 0; i < 16; i++) m_tbl[i] = 8'h00;
        for (int i = 0; i < 4; i++) m_q[i] = '0;
        m_cnt = 0; m_rd = '0;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        // R12 reset state
        compare("R12");

        // R5: table is all 00 after reset, label 00 matches
        lbl_chk_en = 1;
        send(32'hABCD_1200, "R5");
        // R1: label 3C not in table, rejected; R4: nothing changes
        send(32'h1111_113C, "R1");
        send(32'h2222_22C3, "R4");
        do_pop("R6");
        // R9: pop on empty keeps rd_word
        do_pop("R9");
        do_pop("R9");

        // R10: write and word in the same cycle -> old table used
        tbl_addr = 4'd5; tbl_wdata = 8'h3C; tbl_we = 1;
        send(32'h3333_333C, "R10");
        send(32'h4444_443C, "R10");
        do_pop("R10");

        // R2 / R3
        lbl_chk_en = 0; pair_chk_en = 1; want_b10 = 1; want_b9 = 0;
        send(32'h0000_0177, "R3");  // b10=0 b9=1 -> reject
        send(32'h0000_0377, "R3");  // both 1 -> reject
        send(32'h0000_0277, "R3");  // b10=1 b9=0 -> accept
        pair_chk_en = 0;
        send(32'h5555_5599, "R2");
        do_pop("R6"); do_pop("R6"); do_pop("R9");

        // R7: overfill, newest replaced
        for (int i = 0; i < 6; i++) send(32'hA000_0000 + 32'(i), "R7");
        for (int i = 0; i < 5; i++) do_pop("R7");

        // R11: full with simultaneous pop and load
        for (int i = 0; i < 4; i++) send(32'hB000_0000 + 32'(i), "R11");
        pop = 1; send(32'hB000_00FF, "R11");
        pop = 1; send(32'hB000_00EE, "R11");
        for (int i = 0; i < 5; i++) do_pop("R11");

        // load a random table, then random traffic
        for (int i = 0; i < 16; i++) twrite(i, 8'($urandom), "R10");
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] w = $urandom;
            if ($urandom_range(0, 1) == 1) w[7:0] = m_tbl[$urandom_range(0, 15)];
            lbl_chk_en  = 1'($urandom);
            pair_chk_en = 1'($urandom);
            want_b10    = 1'($urandom);
            want_b9     = 1'($urandom);
            pop         = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 15) == 0) begin
                tbl_we = 1; tbl_addr = 4'($urandom); tbl_wdata = 8'($urandom);
            end
            word_in  = w;
            word_stb = ($urandom_range(0, 3) != 0);
            tick("R6");
        end
        finish_run();
    end
endmodule